// File: doc/BRIEF.md
# Byte-Parallel Self-Synchronizing Scrambler

This block whitens a byte stream, one byte per clock, with the recurrence 1 + x^-4 + x^-7. The recurrence is bit-serial: each bit sees the bits four and seven steps back in its own stream. Here the eight bit steps of a byte are chained into one combinational update, so a full byte goes through in each clock. The history lives in a 7-bit tap register.

A mode input picks the direction. In scramble mode each output bit goes back into the tap register. In descramble mode the received bit goes back instead, so the descrambler inverts the scrambler. Because the descrambler's history is built only from the bits it receives, it falls back into step on its own after seven received bits, with no framing.

Both the output byte and its valid flag are registered. An idle cycle freezes the tap register.

Top module: `byte_selfsync_scrambler`

## Requirements
- R1: During reset and after it, out_valid and out_byte are 0. The tap register starts at all ones.
- R2: Bit i of a byte is processed as step i, with bit 0 first. Its output bit is the input bit XOR the bit 4 steps back XOR the bit 7 steps back, in the stream the register holds.
- R3: With mode = 0 (scramble), the output bit of each step is shifted into the register. After a byte, the register holds output bits 7 down to 1 of that byte as delays 1 to 7.
- R4: With mode = 1 (descramble), the received input bit is shifted into the register. Descrambling a scrambled stream from the same start state gives back the original bytes.
- R5: A descrambler whose register holds an arbitrary history yields correct bytes from the second received byte on.
- R6: out_valid equals in_valid of the previous cycle. out_byte is the result for the byte presented in the previous cycle.
- R7: While in_valid is 0, the tap register does not advance and out_byte keeps its value.
- R8: mode is sampled per byte. A change of mode between bytes continues from the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = scramble, 1 = descramble |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Input byte, bit 0 processed first |
| out_valid | output | 1 | Output byte qualifier |
| out_byte | output | 8 | Scrambled or descrambled byte |

## Verification
Zero bytes straight after reset show the all-ones start state and the tap positions, since no data bits mask them. Random bytes with random modes and idle gaps, compared against a serial bit-by-bit model, separate a correct tap order from swapped shift directions or swapped bit order. A scrambled record descrambled from reset checks that the two modes invert each other. The same record, fed after a junk byte, shows that the descrambler recovers within one byte. Held idle cycles tell a frozen register apart from one that advances on idle cycles.

// File: rtl/byte_selfsync_scrambler.sv
module byte_selfsync_scrambler #(
  parameter int LANES    = 8,
  parameter int TAP_NEAR = 4,
  parameter int TAP_FAR  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             in_valid,
  input  logic [LANES-1:0] in_byte,
  output logic             out_valid,
  output logic [LANES-1:0] out_byte
);
  localparam int SW = TAP_FAR;

  // tap_q[k-1] holds the bit k steps back
  logic [SW-1:0]    tap_q;
  logic [SW-1:0]    chain [0:LANES];
  logic [LANES-1:0] obit;

  assign chain[0] = tap_q;

  for (genvar g = 0; g < LANES; g++) begin : g_step
    assign obit[g]     = in_byte[g] ^ chain[g][TAP_NEAR-1] ^ chain[g][TAP_FAR-1];
    assign chain[g+1]  = {chain[g][SW-2:0], mode ? in_byte[g] : obit[g]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q     <= '1;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        tap_q    <= chain[LANES];
        out_byte <= obit;
      end
    end
  end
endmodule

module byte_selfsync_scrambler_chk #(
  parameter int LANES = 8,
  parameter int SW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode,
  input logic             in_valid,
  input logic [LANES-1:0] in_byte,
  input logic             out_valid,
  input logic [LANES-1:0] out_byte,
  input logic [SW-1:0]    st
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!out_valid && out_byte == '0));

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid == $past(in_valid));

  // R7
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(st));

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_byte));

  for (genvar k = 0; k < SW; k++) begin : g_fb
    // R3
    fb_scr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(mode)) |-> st[k] == out_byte[LANES-1-k]);
    // R4
    fb_dsc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode)) |-> st[k] == $past(in_byte[LANES-1-k]));
  end
endmodule

bind byte_selfsync_scrambler byte_selfsync_scrambler_chk #(.LANES(LANES), .SW(TAP_FAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_byte(in_byte),
  .out_valid(out_valid), .out_byte(out_byte), .st(tap_q)
);

// File: tb/byte_selfsync_scrambler_test.sv
module byte_selfsync_scrambler_test;
  localparam int CLK_P = 10;
  localparam int NREC  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid;
  logic [7:0] out_byte;

  int n_cmp = 0;
  int n_bad = 0;

  logic       hist [1:7];
  logic [7:0] exp_byte;
  logic [7:0] plain [0:NREC-1];
  logic [7:0] scr   [0:NREC-1];

  always #(CLK_P/2) clk = ~clk;

  byte_selfsync_scrambler uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte)
  );

  task automatic compare(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // serial reference: hist[k] is the bit k steps back
  task automatic model_byte(input logic md, input logic [7:0] b, output logic [7:0] r);
    for (int i = 0; i < 8; i++) begin
      logic o;
      o = b[i] ^ hist[4] ^ hist[7];
      for (int k = 7; k >= 2; k--) hist[k] = hist[k-1];
      hist[1] = md ? b[i] : o;
      r[i] = o;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    for (int k = 1; k <= 7; k++) hist[k] = 1'b1;
    exp_byte = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic v, input logic md, input logic [7:0] b,
                      input string req, output logic [7:0] got);
    @(negedge clk);
    in_valid = v; mode = md; in_byte = b;
    if (v) model_byte(md, b, exp_byte);
    @(posedge clk);
    #(CLK_P/4);
    compare({7'd0, out_valid}, {7'd0, v}, "R6 valid");
    compare(out_byte, exp_byte, req);
    got = out_byte;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'h5C3A_11E7));

    do_reset();
    #(CLK_P/4);
    compare({7'd0, out_valid}, 8'd0, "R1 valid after reset");
    compare(out_byte, 8'd0, "R1 byte after reset");

    // all-ones start and tap positions, seen through zero data
    step(1'b1, 1'b0, 8'h00, "R1 zero byte from seed", g);
    step(1'b1, 1'b0, 8'h00, "R2 zero byte", g);
    step(1'b1, 1'b0, 8'h01, "R2 bit0 first", g);
    step(1'b1, 1'b0, 8'h80, "R2 bit7 last", g);

    // R7: idle cycles hold output and state
    step(1'b0, 1'b0, 8'hA5, "R7 hold", g);
    step(1'b0, 1'b1, 8'h3C, "R7 hold", g);
    step(1'b0, 1'b0, 8'hFF, "R7 hold", g);
    step(1'b1, 1'b0, 8'h5A, "R7 state frozen", g);

    // R8: mode switching between bytes
    step(1'b1, 1'b1, 8'hC3, "R8 switch to descramble", g);
    step(1'b1, 1'b0, 8'h96, "R8 switch to scramble", g);
    step(1'b1, 1'b1, 8'h0F, "R8 switch again", g);

    // R3: record a scrambled stream from reset
    do_reset();
    for (int i = 0; i < NREC; i++) begin
      plain[i] = 8'($urandom);
      step(1'b1, 1'b0, plain[i], "R3 scramble", scr[i]);
    end

    // R4: round trip from the same start state
    do_reset();
    for (int i = 0; i < NREC; i++) begin
      step(1'b1, 1'b1, scr[i], "R4 descramble", g);
      compare(g, plain[i], "R4 round trip");
    end

    // R5: recovery after a junk history
    do_reset();
    step(1'b1, 1'b1, 8'h6B, "R5 junk byte", g);
    for (int i = 0; i < NREC; i++) begin
      step(1'b1, 1'b1, scr[i], "R5 descramble", g);
      if (i >= 1) compare(g, plain[i], "R5 self-sync recovery");
    end

    // random traffic, modes and gaps
    do_reset();
    for (int n = 0; n < 400; n++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 1'($urandom), 8'($urandom), "R2 random", g);
    end

    report();
  end
endmodule